// File: doc/BRIEF.md
# GPIO Port Interrupt Trigger Unit

This unit turns the synchronised input levels of one GPIO port into a single interrupt request. Each pin has its own trigger condition, chosen from rising edge, falling edge, either edge, high level or low level. A detected condition latches a per-pin status bit. The port interrupt line is raised whenever a latched status bit is also enabled. Software configures the unit, and services interrupts, through a small register port. Writes are decoded by address. Reads are combinational on the address.

The trigger configuration is held in one register with three lanes of `NUM_PINS` bits: polarity, edge mode and both-edge mode. Status bits are cleared through a separate write-one-to-clear address. The enable and trigger registers can also be written through masked addresses, so one pin can be changed without a read-modify-write.

Top module: `gpio_port_irq`

## Requirements
- R1: While reset is asserted, status, enable and trigger read as zero, and `irq_o` is low.
- R2: Trigger lanes are laid out as follows. Bit n sets the polarity of pin n (1 means rising or high). Bit 8+n selects edge mode. Bit 16+n selects both-edge detection when edge mode is set. With pin n, the encodings are: rising 0x101<<n, falling 0x100<<n, both edges 0x10100<<n, high level 0x1<<n, low level 0.
- R3: In rising mode, a status bit is set on the clock edge at which the sampled pin is 1 and the value sampled at the previous edge was 0.
- R4: In falling mode, a status bit is set on the clock edge at which the sampled pin is 0 and the previous sample was 1.
- R5: In both-edge mode, any change between two consecutive samples sets the status bit.
- R6: In level mode, the status bit is set at every clock edge where the pin equals the polarity bit. A cleared bit is therefore set again at the next edge while the level persists.
- R7: A write to address 3 clears each status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R8: If a trigger event and a clear of the same pin fall on the same clock edge, the status bit ends up set.
- R9: `irq_o` equals the OR over pins of status AND enable. Status bits latch whether or not the pin is enabled.
- R10: A write to address 4 updates only the enable bits whose mask bit in `wdata_i[15:8]` is 1, taking their new values from `wdata_i[7:0]`.
- R11: A write to address 5 updates only the pins whose mask bit in `wdata_i[31:24]` is 1. For each such pin, all three trigger lanes take their values from `wdata_i[23:0]`.
- R12: Address 1 writes enable from `wdata_i[7:0]`. Address 2 writes trigger from `wdata_i[23:0]`. Reads of address 0, 1 and 2 return status, enable and trigger, zero-extended, and every other address reads 0. A write to address 0 changes nothing.
- R13: An edge-triggered status bit stays set until it is cleared. After a clear, it stays clear until the next qualifying edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | NUM_PINS | Synchronised pin levels |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| irq_o | output | 1 | Port interrupt request |

## Verification
Directed phases place each of the five trigger modes on separate pins. Each pin is then toggled on its own, so that a wrong polarity or a wrong lane decode shows up as a status bit on the wrong pin. Clears are issued with mixed one and zero bits, in the same cycle as a new edge, and while a level is still active. These cases separate write-one-to-clear from plain write, set-over-clear priority, and level re-arming from edge latching. Masked writes use a partial mask over pins whose values differ, so that an unmasked write shows up as a changed neighbour. A long random phase then mixes pin noise with every register address, and checks the read data against a behavioural model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] A_STATUS   = 3'd0;
  localparam logic [REG_ADDR_W-1:0] A_EN       = 3'd1;
  localparam logic [REG_ADDR_W-1:0] A_TRIG     = 3'd2;
  localparam logic [REG_ADDR_W-1:0] A_CLEAR    = 3'd3;
  localparam logic [REG_ADDR_W-1:0] A_EN_MSK   = 3'd4;
  localparam logic [REG_ADDR_W-1:0] A_TRIG_MSK = 3'd5;

  typedef struct packed {
    logic both;
    logic edge_mode;
    logic pol;
  } pin_mode_t;
endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [REG_ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [NUM_PINS-1:0]     en_o,
  output logic [3*NUM_PINS-1:0]   trig_o
);
  localparam int unsigned TW = 3 * NUM_PINS;

  logic [NUM_PINS-1:0] en_q;
  logic [TW-1:0]       trig_q;
  logic [NUM_PINS-1:0] en_mask, trig_pin_mask;
  logic [TW-1:0]       trig_mask;

  assign en_mask       = wdata_i[2*NUM_PINS-1:NUM_PINS];
  assign trig_pin_mask = wdata_i[4*NUM_PINS-1:3*NUM_PINS];
  assign trig_mask     = {3{trig_pin_mask}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      trig_q <= '0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        A_EN:       en_q   <= wdata_i[NUM_PINS-1:0];
        A_EN_MSK:   en_q   <= (en_q & ~en_mask) | (wdata_i[NUM_PINS-1:0] & en_mask);
        A_TRIG:     trig_q <= wdata_i[TW-1:0];
        A_TRIG_MSK: trig_q <= (trig_q & ~trig_mask) | (wdata_i[TW-1:0] & trig_mask);
        default: ;
      endcase
    end
  end

  assign en_o   = en_q;
  assign trig_o = trig_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_PINS-1:0]     pins_i,
  input  logic [3*NUM_PINS-1:0]   trig_i,
  output logic [NUM_PINS-1:0]     hit_o
);
  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pins_i;
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    pin_mode_t mode;
    logic rise, fall, edge_hit, lvl_hit;

    assign mode.pol       = trig_i[n];
    assign mode.edge_mode = trig_i[NUM_PINS + n];
    assign mode.both      = trig_i[2*NUM_PINS + n];

    assign rise     = pins_i[n] & ~prev_q[n];
    assign fall     = ~pins_i[n] & prev_q[n];
    assign edge_hit = mode.both ? (rise | fall) : (mode.pol ? rise : fall);
    assign lvl_hit  = (pins_i[n] == mode.pol);
    assign hit_o[n] = mode.edge_mode ? edge_hit : lvl_hit;
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] hit_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] status_o
);
  logic [NUM_PINS-1:0] status_q;

  // set dominates clear so no edge is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | hit_i;
  end

  assign status_o = status_q;
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PINS-1:0]   pins_i,
  input  logic                  wr_en_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  irq_o
);
  localparam int unsigned TW = 3 * NUM_PINS;

  logic [NUM_PINS-1:0] en_q, status_q, hit, clr;
  logic [TW-1:0]       trig_q;

  assign clr = (wr_en_i && addr_i == A_CLEAR) ? wdata_i[NUM_PINS-1:0] : '0;

  gpio_irq_cfg #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .en_o(en_q), .trig_o(trig_q)
  );

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_det (
    .clk_i, .rst_ni, .pins_i, .trig_i(trig_q), .hit_o(hit)
  );

  gpio_irq_status #(.NUM_PINS(NUM_PINS)) u_sts (
    .clk_i, .rst_ni, .hit_i(hit), .clr_i(clr), .status_o(status_q)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_STATUS: rdata_o[NUM_PINS-1:0] = status_q;
      A_EN:     rdata_o[NUM_PINS-1:0] = en_q;
      A_TRIG:   rdata_o[TW-1:0]       = trig_q;
      default: ;
    endcase
  end

  assign irq_o = |(status_q & en_q);
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned DATA_W   = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_PINS-1:0]   pins_i,
  input logic                  wr_en_i,
  input logic [REG_ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0]     wdata_i,
  input logic                  irq_o,
  input logic [NUM_PINS-1:0]   status_q,
  input logic [NUM_PINS-1:0]   en_q,
  input logic [3*NUM_PINS-1:0] trig_q
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((en_q != '0) && (status_q != '0)));

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_chk
    logic clr_n, edge_n;
    assign clr_n  = wr_en_i && addr_i == A_CLEAR && wdata_i[n];
    assign edge_n = trig_q[NUM_PINS + n];

    assert_sticky_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_q[n] && !clr_n) |=> status_q[n]);

    assert_clear_effective_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && clr_n && edge_n && $stable(pins_i[n])) |=> !status_q[n]);

    assert_edge_quiet_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && edge_n && $stable(pins_i[n]) && !status_q[n]) |=> !status_q[n]);
  end
endmodule

bind gpio_port_irq gpio_irq_checker #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pins_i(pins_i), .wr_en_i(wr_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .irq_o(irq_o),
  .status_q(status_q), .en_q(en_q), .trig_q(trig_q)
);

// File: tb/gpio_port_irq_test.sv
`timescale 1ns/1ps
module gpio_port_irq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins = 8'h00;
  logic        wr = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;

  gpio_port_irq uut (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .wr_en_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #4 clk = ~clk;

  // behavioural reference
  int m_status, m_en, m_trig, m_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_status <= 0; m_en <= 0; m_trig <= 0; m_prev <= 0;
    end else begin
      int nxt, msk;
      nxt = m_status;
      if (wr && addr == 3) nxt = nxt & ~int'(wdata[7:0]);
      for (int n = 0; n < 8; n++) begin
        int cur, old, pol, edg, bth, hit;
        cur = pins[n]; old = (m_prev >> n) & 1;
        pol = (m_trig >> n) & 1; edg = (m_trig >> (8+n)) & 1; bth = (m_trig >> (16+n)) & 1;
        if (edg == 0)      hit = (cur == pol);
        else if (bth != 0) hit = (cur != old);
        else if (pol != 0) hit = (cur == 1 && old == 0);
        else               hit = (cur == 0 && old == 1);
        if (hit != 0) nxt = nxt | (1 << n);
      end
      m_status <= nxt;
      m_prev <= int'(pins);
      if (wr) begin
        case (addr)
          3'd1: m_en <= int'(wdata[7:0]);
          3'd2: m_trig <= int'(wdata[23:0]);
          3'd4: begin msk = int'(wdata[15:8]); m_en <= (m_en & ~msk) | (int'(wdata[7:0]) & msk); end
          3'd5: begin
            msk = int'(wdata[31:24]); msk = msk | (msk << 8) | (msk << 16);
            m_trig <= (m_trig & ~msk) | (int'(wdata[23:0]) & msk);
          end
          default: ;
        endcase
      end
    end
  end

  function automatic int model_read(input logic [2:0] a);
    case (a)
      3'd0: return m_status;
      3'd1: return m_en;
      3'd2: return m_trig;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // irq compared against the model every cycle (R9)
  always @(negedge clk) if (rst_n && !done) check("R9 irq", int'(irq), int'((m_status & m_en) != 0));

  task automatic drive(input logic [7:0] p, input logic w, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    pins = p; wr = w; addr = a; wdata = d;
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    drive(pins, 1'b1, a, d);
  endtask

  task automatic setp(input logic [7:0] p);
    drive(p, 1'b0, addr, wdata);
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    drive(pins, 1'b0, a, 32'h0);
    #1 check(tag, int'(rdata), model_read(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    pins = 8'hF0;
    repeat (2) @(negedge clk);
    #1;
    check("R1 status", int'(rdata), 0);
    addr = 3'd1; #1 check("R1 enable", int'(rdata), 0);
    addr = 3'd2; #1 check("R1 trigger", int'(rdata), 0);
    check("R1 irq", int'(irq), 0);
    rst_n = 1'b1;

    // R2: pin0 rise, pin1 fall, pin2 both, pin3 high, pin4-7 low
    wreg(3'd2, 32'h0000_0101 | 32'h0000_0200 | 32'h0004_0400 | 32'h0000_0008);
    rd(3'd2, "R2 trigger layout");
    wreg(3'd3, 32'hFF); rd(3'd0, "R7 clear all");
    wreg(3'd1, 32'h0F); rd(3'd1, "R12 enable write");

    setp(8'hF1); rd(3'd0, "R3 rising sets pin0");
    setp(8'hF0); rd(3'd0, "R3 falling ignored on rising pin");
    wreg(3'd3, 32'h01); rd(3'd0, "R13 clear edge bit");
    setp(8'hF0); rd(3'd0, "R13 stays clear without edge");
    setp(8'hF2); rd(3'd0, "R4 rise ignored on falling pin");
    setp(8'hF0); rd(3'd0, "R4 falling sets pin1");
    setp(8'hF4); rd(3'd0, "R5 both rise");
    wreg(3'd3, 32'h04); setp(8'hF0); rd(3'd0, "R5 both fall");
    setp(8'hF8); rd(3'd0, "R6 high level");
    wreg(3'd3, 32'h08); rd(3'd0, "R6 level re-sets after clear");
    setp(8'hE0); rd(3'd0, "R6 low level pin4");
    wreg(3'd3, 32'h10); setp(8'hF0); rd(3'd0, "R6 low level cleared");
    wreg(3'd3, 32'h02); rd(3'd0, "R7 zeros leave others");
    // R8: edge and clear in same cycle
    drive(8'hF1, 1'b1, 3'd3, 32'h01); rd(3'd0, "R8 set wins");
    // R9: status latches while disabled
    wreg(3'd1, 32'h00); wreg(3'd3, 32'hFF); setp(8'hF0); setp(8'hF1);
    rd(3'd0, "R9 status without enable"); check("R9 irq disabled", int'(irq), 0);
    wreg(3'd1, 32'h01); rd(3'd1, "R9 enable raises irq");
    wreg(3'd4, 32'h0000_06FF); rd(3'd1, "R10 masked enable");
    wreg(3'd4, 32'h0000_0100); rd(3'd1, "R10 masked enable clear");
    wreg(3'd5, 32'h0200_0000); rd(3'd2, "R11 masked trigger pin1");
    wreg(3'd5, 32'h8180_8080); rd(3'd2, "R11 masked trigger pin0 pin7");
    wreg(3'd0, 32'hFFFF_FFFF); rd(3'd0, "R12 write to status ignored");
    rd(3'd1, "R12 enable after status write"); rd(3'd2, "R12 trigger after status write");
    rd(3'd6, "R12 unused address"); rd(3'd7, "R12 unused address 7");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [2:0] a;
      a = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 2) == 0) drive(8'($urandom), 1'b1, a, $urandom);
      else drive(8'($urandom), 1'b0, a, 32'h0);
      rd(3'($urandom_range(0, 3)), "R2 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule